// File: doc/BRIEF.md
# Clock Configuration Register Slave on I2C

This block is a slave on a two-wire serial bus and holds a small bank of 8-bit configuration registers for a clock device. It oversamples the bus clock and data lines on the system clock. It detects START and STOP conditions and matches the device address. It drives the data line open-drain through a single active-high pull-down enable. The register bank is also presented in parallel to the rest of the chip.

A write always uses the block form. After the address, the host sends two bytes, a command code and a count. Both are acknowledged and then discarded. The bytes that follow fill the registers in order from register 0, and the host may stop after any whole byte.

A read always uses the block form too. The slave first returns a count byte and then streams the registers from the lowest index upward. The host acknowledges each byte, and a host NACK ends the stream.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: On reset, register i holds byte i of 0x0FFFFF5A00FF7EC3, counting from the least significant byte, and `cfg_out[8i+7:8i]` shows register i. While idle, `sda_oe` is 0.
- R2: The slave acknowledges (pulls SDA low in the ninth clock) only the address bytes 0xD4 (write) and 0xD5 (read). For any other address it sends no ACK and keeps SDA released until the next START.
- R3: In a write, the two bytes after the address are acknowledged and change no register.
- R4: In a write, the third and later bytes after the address are stored in register 0, 1, 2, and so on, in arrival order. Each one is acknowledged.
- R5: A STOP after any complete byte ends the write. Registers written so far keep their new values, and all the others keep their old values.
- R6: Data bytes beyond the eighth are acknowledged and do not change any register.
- R7: A read returns the count byte 0x08, then registers 0 to 7, all MSB first. While the host keeps acknowledging after register 7, each further byte is 0xFF. A read never changes a register.
- R8: When the host NACKs a byte during a read, the slave releases SDA and drives nothing more until a STOP or a START.
- R9: A repeated START at any point restarts address reception. A new write then begins again with its two discarded bytes and register 0.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| cfg_out | output | 64 | Register contents; register i sits at bits 8i+7:8i |

## Verification
The hardest states to reach from the ports come up in the middle of a transfer. The first is a host NACK in the middle of a read, where the slave must release SDA for a byte and then wait for STOP. The second is a repeated START that cuts into a write, where the register index must start over at the discarded bytes. The bench reaches both with directed transactions through its own bit-level master. It then checks the bus line bit by bit and checks the parallel output after the STOP. Random write lengths from zero to past the register count then cover every partial-write boundary. Each random write is followed by a full read-back, with the expected bank kept in a bench model.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } ctlState_t;

  typedef struct packed {
    logic shiftIn;   // sample SDA into receive shifter, count a bit
    logic bitClr;    // clear bit counter
    logic commitRx;  // received byte is complete: store/skip, advance index
    logic loadTx;    // load next outgoing byte, advance index
    logic shiftTx;   // move next outgoing bit to the MSB
    logic idxClr;    // new transfer: byte index back to zero
  } dpStrobe_t;

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclQ, sdaQ;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclQ <= '1;
      sdaQ <= '1;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclQ <= {sclQ[STAGES-2:0], scl_i};
      sdaQ <= {sdaQ[STAGES-2:0], sda_i};
      sclD <= sclQ[STAGES-1];
      sdaD <= sdaQ[STAGES-1];
    end
  end

  assign sclS     = sclQ[STAGES-1];
  assign sdaS     = sdaQ[STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/clkcfg_dp.sv
module clkcfg_dp
  import clkcfg_pkg::*;
#(
  parameter int                    NUM_REGS    = 8,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUE = 64'h0FFFFF5A00FF7EC3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dpStrobe_t             stb,
  input  logic                  sdaS,
  output logic [3:0]            bitCnt,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] cfgOut
);
  localparam int IDX_MAX = NUM_REGS + 2;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);

  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       txShift;
  logic [7:0]       txNext;
  logic [7:0]       regs [NUM_REGS];
  logic             idxFull;

  assign idxFull = (byteIdx == IDX_W'(IDX_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt  <= '0;
      rxByte  <= '0;
      txShift <= 8'hFF;
      byteIdx <= '0;
    end else begin
      if (stb.bitClr)
        bitCnt <= '0;
      else if (stb.shiftIn)
        bitCnt <= bitCnt + 4'd1;
      if (stb.shiftIn)
        rxByte <= {rxByte[6:0], sdaS};
      if (stb.loadTx)
        txShift <= txNext;
      else if (stb.shiftTx)
        txShift <= {txShift[6:0], 1'b1};
      if (stb.idxClr)
        byteIdx <= '0;
      else if ((stb.commitRx || stb.loadTx) && !idxFull)
        byteIdx <= byteIdx + 1'b1;
    end
  end

  // Outgoing byte: count first, then the bank, then released line.
  always_comb begin
    txNext = 8'hFF;
    if (byteIdx == '0)
      txNext = 8'(NUM_REGS);
    for (int i = 0; i < NUM_REGS; i++)
      if (byteIdx == IDX_W'(i + 1))
        txNext = regs[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= RESET_VALUE[8*g +: 8];
      else if (stb.commitRx && byteIdx == IDX_W'(g + 2))
        regs[g] <= rxByte;
    end
    assign cfgOut[8*g +: 8] = regs[g];
  end

  assign txMsb = txShift[7];
endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  input  logic      txMsb,
  output dpStrobe_t stb,
  output logic      sdaOe,
  output ctlState_t state
);
  ctlState_t stateN;
  logic      isRead, isReadN;
  logic      byteDone;

  assign byteDone = sclFall && (bitCnt == 4'd8);

  always_comb begin
    stateN  = state;
    isReadN = isRead;
    stb     = '0;
    if (stopDet) begin
      stateN = ST_IDLE;
    end else if (startDet) begin
      stateN     = ST_ADDR;
      stb.bitClr = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) stb.shiftIn = 1'b1;
          else if (byteDone) begin
            if (rxByte[7:1] == DEV_ADDR) begin
              isReadN    = rxByte[0];
              stb.idxClr = 1'b1;
              stateN     = ST_ADDR_ACK;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            stb.bitClr = 1'b1;
            if (isRead) begin
              stb.loadTx = 1'b1;
              stateN     = ST_TX;
            end else begin
              stateN = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (sclRise) stb.shiftIn = 1'b1;
          else if (byteDone) begin
            stb.commitRx = 1'b1;
            stateN       = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            stb.bitClr = 1'b1;
            stateN     = ST_RX;
          end
        end
        ST_TX: begin
          if (sclRise) stb.shiftIn = 1'b1;
          else if (byteDone) begin
            stb.bitClr = 1'b1;
            stateN     = ST_TX_ACK;
          end else if (sclFall) begin
            stb.shiftTx = 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) stb.shiftIn = 1'b1;
          else if (sclFall) begin
            if (!rxByte[0]) begin
              stb.bitClr = 1'b1;
              stb.loadTx = 1'b1;
              stateN     = ST_TX;
            end else begin
              stateN = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
    end else begin
      state  <= stateN;
      isRead <= isReadN;
    end
  end

  // Drive only in ACK slots and for zero bits of an outgoing byte.
  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_RX_ACK) ||
                 ((state == ST_TX) && !txMsb);
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter int                    NUM_REGS    = 8,
  parameter logic [6:0]            DEV_ADDR    = 7'h6A,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUE = 64'h0FFFFF5A00FF7EC3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_out
);
  logic      sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;
  logic      txMsb;
  dpStrobe_t stb;
  ctlState_t ctlState;

  clkcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  clkcfg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .bitCnt(bitCnt),
    .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .sdaOe(sda_oe),
    .state(ctlState)
  );

  clkcfg_dp #(.NUM_REGS(NUM_REGS), .RESET_VALUE(RESET_VALUE)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sdaS(sdaS), .bitCnt(bitCnt),
    .rxByte(rxByte), .txMsb(txMsb), .cfgOut(cfg_out)
  );
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk
  import clkcfg_pkg::*;
#(
  parameter int CFG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclS,
  input logic             sdaOe,
  input logic [CFG_W-1:0] cfgOut,
  input ctlState_t        state,
  input logic [3:0]       bitCnt
);
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclS && $past(sclS)) |-> $stable(sdaOe)); // R10

  AST_RELEASED_OUTSIDE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_WAIT || state == ST_ADDR ||
     state == ST_RX || state == ST_TX_ACK) |-> !sdaOe); // R8

  AST_CFG_CHANGE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgOut != $past(cfgOut)) |-> (state == ST_RX_ACK)); // R4

  AST_READ_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX || state == ST_TX_ACK) |-> $stable(cfgOut)); // R7

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= 4'd8); // R10
endmodule

bind clkcfg_i2c_slave clkcfg_chk #(.CFG_W(NUM_REGS*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclS(sclS), .sdaOe(sda_oe),
  .cfgOut(cfg_out), .state(ctlState), .bitCnt(bitCnt)
);

// File: tb/sim_clkcfg_i2c_slave.sv
`timescale 1ns/1ps
module sim_clkcfg_i2c_slave;
  localparam int Q = 8;
  localparam logic [63:0] DEF = 64'h0FFFFF5A00FF7EC3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sda_oe;
  logic [63:0] cfg_out;
  wire  sdaLine = sdaM & ~sda_oe;

  int nChecks = 0;
  int nErr = 0;
  int r10Viol = 0;
  bit done = 0;
  logic [7:0] expRegs [8];
  logic [7:0] wrData [16];

  always #5 clk = ~clk;

  clkcfg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(sclM), .sda_i(sdaLine),
    .sda_oe(sda_oe), .cfg_out(cfg_out)
  );

  // R10 monitor: drive must not move while the bus clock is high
  logic prevScl = 1'b1, prevOe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sclM && prevScl && (sda_oe != prevOe)) r10Viol++;
    prevScl <= sclM;
    prevOe  <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expFlat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[8*i +: 8] = expRegs[i];
    return f;
  endfunction

  task automatic qw; repeat (Q) @(negedge clk); endtask
  task automatic startC; sdaM = 1; qw; sclM = 1; qw; sdaM = 0; qw; sclM = 0; qw; endtask
  task automatic stopC;  sdaM = 0; qw; sclM = 1; qw; sdaM = 1; qw; qw; endtask
  task automatic putBit(input logic b); sdaM = b; qw; sclM = 1; qw; qw; sclM = 0; qw; endtask
  task automatic getBit(output logic b);
    sdaM = 1; qw; sclM = 1; qw; b = sdaLine; qw; sclM = 0; qw;
  endtask
  task automatic wrByte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ack = !b;
  endtask
  task automatic rdByte(output logic [7:0] v, input bit ack);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    putBit(!ack);
  endtask

  // Block write of n data bytes from wrData; optional STOP
  task automatic doWrite(input int n, input logic [7:0] cmdB, input logic [7:0] cntB, input bit withStop);
    bit ack;
    startC;
    wrByte(8'hD4, ack); chk(ack, "R2 write address ack", 64'(ack), 64'd1);
    wrByte(cmdB, ack);  chk(ack, "R3 command byte ack", 64'(ack), 64'd1);
    wrByte(cntB, ack);  chk(ack, "R3 count byte ack", 64'(ack), 64'd1);
    chk(cfg_out == expFlat(), "R3 dummy bytes leave bank", cfg_out, expFlat());
    for (int i = 0; i < n; i++) begin
      wrByte(wrData[i], ack);
      chk(ack, (i < 8) ? "R4 data byte ack" : "R6 extra byte ack", 64'(ack), 64'd1);
      if (i < 8) expRegs[i] = wrData[i];
    end
    if (withStop) begin
      stopC;
      chk(cfg_out == expFlat(), "R5 bank after STOP", cfg_out, expFlat());
    end
  endtask

  // Full block read, optional extra byte past the bank
  task automatic doRead(input bit extra);
    bit ack;
    logic [7:0] v;
    startC;
    wrByte(8'hD5, ack); chk(ack, "R2 read address ack", 64'(ack), 64'd1);
    rdByte(v, 1'b1);    chk(v == 8'h08, "R7 count byte", 64'(v), 64'h08);
    for (int i = 0; i < 8; i++) begin
      rdByte(v, (i < 7) || extra);
      chk(v == expRegs[i], "R7 register read", 64'(v), 64'(expRegs[i]));
    end
    if (extra) begin
      rdByte(v, 1'b0);
      chk(v == 8'hFF, "R7 byte past bank", 64'(v), 64'hFF);
    end
    stopC;
  endtask

  initial begin
    bit ack;
    logic [7:0] v;
    void'($urandom(32'd1357));
    for (int i = 0; i < 8; i++) expRegs[i] = DEF[8*i +: 8];
    #2 rst_n = 0;
    repeat (4) @(negedge clk);
    chk(cfg_out == DEF, "R1 reset bank", cfg_out, DEF);
    chk(sda_oe == 1'b0, "R1 idle release", 64'(sda_oe), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 read of defaults, with extra byte past the bank (R7)
    doRead(1'b1);

    // R3/R4/R5 partial write of three bytes, dummies carry data-like values
    wrData[0] = 8'h12; wrData[1] = 8'h34; wrData[2] = 8'h56;
    doWrite(3, 8'hAB, 8'hCD, 1'b1);
    doRead(1'b0);

    // R6 eleven data bytes: three extras ignored
    for (int i = 0; i < 11; i++) wrData[i] = 8'(8'h80 + 8'(i * 17));
    doWrite(11, 8'h00, 8'h08, 1'b1);
    doRead(1'b0);

    // R2 unmatched addresses: no ACK, line stays released, bank untouched
    startC;
    wrByte(8'hA0, ack); chk(!ack, "R2 foreign address no ack", 64'(ack), 64'd0);
    wrByte(8'h00, ack); chk(!ack, "R2 released after mismatch", 64'(ack), 64'd0);
    stopC;
    startC;
    wrByte(8'hD6, ack); chk(!ack, "R2 near address no ack", 64'(ack), 64'd0);
    wrByte(8'h00, ack); chk(!ack, "R2 released after mismatch", 64'(ack), 64'd0);
    stopC;
    chk(cfg_out == expFlat(), "R2 bank unchanged by foreign access", cfg_out, expFlat());

    // R8 host NACK after first register: following byte reads as all ones
    startC;
    wrByte(8'hD5, ack);
    rdByte(v, 1'b1); chk(v == 8'h08, "R7 count byte", 64'(v), 64'h08);
    rdByte(v, 1'b0); chk(v == expRegs[0], "R8 byte before NACK", 64'(v), 64'(expRegs[0]));
    rdByte(v, 1'b0); chk(v == 8'hFF, "R8 released after NACK", 64'(v), 64'hFF);
    stopC;
    chk(cfg_out == expFlat(), "R8 bank unchanged", cfg_out, expFlat());

    // R9 repeated START in a write restarts at the dummy bytes and register 0
    wrData[0] = 8'h11; wrData[1] = 8'h99;
    doWrite(2, 8'h00, 8'h00, 1'b0);
    wrData[0] = 8'h22;
    doWrite(1, 8'h77, 8'h66, 1'b1);
    chk(cfg_out[15:0] == 16'h9922, "R9 restart at register 0", 64'(cfg_out[15:0]), 64'h9922);
    // R9 repeated START into a read
    wrData[0] = 8'h3C;
    doWrite(1, 8'h00, 8'h00, 1'b0);
    doRead(1'b0);

    // Random block writes of 0..10 bytes, each followed by a full read-back
    for (int it = 0; it < 10; it++) begin
      int n;
      n = int'($urandom % 11);
      for (int i = 0; i < n; i++) wrData[i] = 8'($urandom);
      doWrite(n, 8'($urandom), 8'($urandom), 1'b1);
      doRead(1'b0);
    end

    chk(r10Viol == 0, "R10 drive stable while SCL high", 64'(r10Viol), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end
endmodule